// File: doc/BRIEF.md
# Single-Cycle Word Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It fetches from an instruction port, decodes the opcode with purely combinational logic, reads two operands from a 32-entry register file, runs them through an ALU and, in the same cycle, commits the result. The result can go to the register file, to the data port, or to the program counter. Instruction memory and data memory sit outside the core on two separate ports, so a fetch and a data access never compete.

The instruction set is small and fixed. It covers three-register ALU operations selected by the function field, add-immediate, word load, word store, branch-if-equal and an absolute jump. Data accesses are always whole 32-bit words at 4-byte aligned addresses. The core is meant to be dropped next to two simple synchronous-write, combinational-read memories, such as small on-chip RAMs or a test model.

Top module: `onecycle_core`

## Requirements
- R1: While reset is asserted the fetch address equals RESET_PC (default 0) and no data write is issued. After release, execution starts at RESET_PC with all registers holding zero.
- R2: Opcode 0x00 is a register operation. The fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and function[5:0]. The result is written to rd. The function codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor and 0x2A signed set-less-than (result 1 or 0).
- R3: Opcode 0x08 writes rs + sign-extended imm[15:0] into rt.
- R4: Opcode 0x23 loads the data word at rs + sign-extended imm[15:0] into rt. Opcode 0x2B stores rt to that address. A data write is issued only for opcode 0x2B.
- R5: Opcode 0x04 compares rs with rt. When they are equal, the next fetch is at (PC+4) + (sign-extended imm[15:0] << 2); otherwise it is at PC+4. Negative offsets move backwards.
- R6: Opcode 0x02 makes the next fetch {PC+4[31:28], instr[25:0], 2'b00}.
- R7: Register 0 always reads as zero, and a write that targets it leaves it at zero.
- R8: An unknown opcode, or opcode 0x00 with an unknown function code, writes neither the register file nor data memory, and the PC advances by 4.
- R9: Every non-control instruction advances the fetch address by exactly 4 on the next edge. The PC, the register file and the data memory are all committed on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state commits on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Fetch address (current PC) |
| imem_data | input | 32 | Instruction word at imem_addr, combinational |
| dmem_addr | output | 32 | Data word address (rs + sign-extended offset) |
| dmem_wdata | output | 32 | Store data (value of rt) |
| dmem_we | output | 1 | Store enable, sampled by the memory on the rising edge |
| dmem_rdata | input | 32 | Data word at dmem_addr, combinational |

## Verification
The hardest situation to reach from the ports is a register value that is never seen directly. A register is only visible once a later store copies it out. A discarded write to register 0, an ignored unknown opcode, or a skipped instruction leaves no mark unless the stimulus makes it show. The program is therefore arranged so that each such case would otherwise cause an extra or different store: a bad opcode carrying a store-like immediate, instructions skipped by a branch that would add to a counter, and a store placed behind a jump. A scoreboard of expected stores then catches any deviation, and a backward loop plus a final self-jump confirm the branch and jump targets through the fetch address.

// File: rtl/oc_pkg.sv
package oc_pkg;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_ADDI  = 6'h08;
   localparam logic [5:0] OP_LOAD  = 6'h23;
   localparam logic [5:0] OP_STORE = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_JUMP  = 6'h02;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_XOR = 6'h26;
   localparam logic [5:0] FN_NOR = 6'h27;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT
   } alu_op_e;

   typedef struct packed {
      logic    reg_we;
      logic    mem_we;
      logic    dst_rd;
      logic    src_imm;
      logic    mem_to_reg;
      logic    branch;
      logic    jump;
      alu_op_e alu_op;
   } ctrl_t;

   // Whether a function code is implemented, given the ALU variant.
   function automatic logic funct_known(input logic [5:0] f, input bit ext);
      if (f == FN_ADD || f == FN_SUB) return 1'b1;
      if (!ext) return 1'b0;
      return (f == FN_AND) || (f == FN_OR) || (f == FN_XOR) ||
             (f == FN_NOR) || (f == FN_SLT);
   endfunction

   function automatic alu_op_e funct_to_op(input logic [5:0] f);
      case (f)
         FN_SUB:  return ALU_SUB;
         FN_AND:  return ALU_AND;
         FN_OR:   return ALU_OR;
         FN_XOR:  return ALU_XOR;
         FN_NOR:  return ALU_NOR;
         FN_SLT:  return ALU_SLT;
         default: return ALU_ADD;
      endcase
   endfunction

endpackage

// File: rtl/oc_decode.sv
module oc_decode
   import oc_pkg::*;
#(
   parameter bit EXT_FUNCT = 1'b1
) (
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);

   always_comb begin
      // Everything off: unknown encodings fall through as no-ops.
      ctrl = '0;
      ctrl.alu_op = ALU_ADD;
      case (opcode)
         OP_RTYPE: begin
            ctrl.reg_we = funct_known(funct, EXT_FUNCT);
            ctrl.dst_rd = 1'b1;
            ctrl.alu_op = funct_to_op(funct);
         end
         OP_ADDI: begin
            ctrl.reg_we  = 1'b1;
            ctrl.src_imm = 1'b1;
         end
         OP_LOAD: begin
            ctrl.reg_we     = 1'b1;
            ctrl.src_imm    = 1'b1;
            ctrl.mem_to_reg = 1'b1;
         end
         OP_STORE: begin
            ctrl.mem_we  = 1'b1;
            ctrl.src_imm = 1'b1;
         end
         OP_BEQ: begin
            ctrl.branch = 1'b1;
            ctrl.alu_op = ALU_SUB;
         end
         OP_JUMP: begin
            ctrl.jump = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/oc_alu.sv
module oc_alu
   import oc_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit EXT_FUNCT = 1'b1
) (
   input  alu_op_e          op,
   input  logic [XLEN-1:0]  a,
   input  logic [XLEN-1:0]  b,
   output logic [XLEN-1:0]  y,
   output logic             zero
);

   generate
      if (EXT_FUNCT) begin : g_full
         always_comb begin
            case (op)
               ALU_SUB: y = a - b;
               ALU_AND: y = a & b;
               ALU_OR:  y = a | b;
               ALU_XOR: y = a ^ b;
               ALU_NOR: y = ~(a | b);
               ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
               default: y = a + b;
            endcase
         end
      end else begin : g_addsub
         always_comb y = (op == ALU_SUB) ? (a - b) : (a + b);
      end
   endgenerate

   assign zero = (y == '0);

endmodule

// File: rtl/oc_regfile.sv
module oc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   ra1,
   input  logic [AW-1:0]   ra2,
   input  logic [AW-1:0]   wa,
   input  logic            we,
   input  logic [XLEN-1:0] wd,
   output logic [XLEN-1:0] rd1,
   output logic [XLEN-1:0] rd2
);

   logic [XLEN-1:0] q_all [NREG];

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         if (i == 0) begin : g_zero
            assign q_all[i] = '0;
         end else begin : g_flop
            logic [XLEN-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                         q <= '0;
               else if (we && wa == AW'(i))        q <= wd;
            end
            assign q_all[i] = q;
         end
      end
   endgenerate

   assign rd1 = q_all[ra1];
   assign rd2 = q_all[ra2];

endmodule

// File: rtl/onecycle_core.sv
module onecycle_core
   import oc_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter int          NREG      = 32,
   parameter bit          EXT_FUNCT = 1'b1,
   parameter logic [31:0] RESET_PC  = 32'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [31:0] imem_addr,
   input  logic [31:0] imem_data,
   output logic [31:0] dmem_addr,
   output logic [31:0] dmem_wdata,
   output logic        dmem_we,
   input  logic [31:0] dmem_rdata
);

   localparam int AW = $clog2(NREG);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("onecycle_core: instruction fields assume XLEN of 32");
      end
      if (NREG < 2 || NREG > 32 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("onecycle_core: NREG must be a power of two from 2 to 32");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_pc
         $error("onecycle_core: RESET_PC must be word aligned");
      end
   endgenerate

   logic [XLEN-1:0] pc, pc_plus4, pc_next, br_tgt, jmp_tgt;
   logic [XLEN-1:0] rs_val, rt_val, imm_sx, alu_b, alu_y, wb_val;
   logic [AW-1:0]   wa;
   logic            alu_zero, rf_we;
   ctrl_t           ctrl;

   // Field extraction
   logic [5:0]  f_op, f_fn;
   logic [4:0]  f_rs, f_rt, f_rd;
   logic [15:0] f_imm;
   logic [25:0] f_tgt;

   assign f_op  = imem_data[31:26];
   assign f_rs  = imem_data[25:21];
   assign f_rt  = imem_data[20:16];
   assign f_rd  = imem_data[15:11];
   assign f_fn  = imem_data[5:0];
   assign f_imm = imem_data[15:0];
   assign f_tgt = imem_data[25:0];

   oc_decode #(.EXT_FUNCT(EXT_FUNCT)) u_dec (
      .opcode (f_op),
      .funct  (f_fn),
      .ctrl   (ctrl)
   );

   oc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra1   (f_rs[AW-1:0]),
      .ra2   (f_rt[AW-1:0]),
      .wa    (wa),
      .we    (rf_we),
      .wd    (wb_val),
      .rd1   (rs_val),
      .rd2   (rt_val)
   );

   assign imm_sx = {{(XLEN-16){f_imm[15]}}, f_imm};
   assign alu_b  = ctrl.src_imm ? imm_sx : rt_val;

   oc_alu #(.XLEN(XLEN), .EXT_FUNCT(EXT_FUNCT)) u_alu (
      .op   (ctrl.alu_op),
      .a    (rs_val),
      .b    (alu_b),
      .y    (alu_y),
      .zero (alu_zero)
   );

   assign wa     = ctrl.dst_rd ? f_rd[AW-1:0] : f_rt[AW-1:0];
   assign wb_val = ctrl.mem_to_reg ? dmem_rdata : alu_y;
   assign rf_we  = ctrl.reg_we & rst_n;

   assign dmem_addr  = alu_y;
   assign dmem_wdata = rt_val;
   assign dmem_we    = ctrl.mem_we & rst_n;

   // Next-PC selection
   assign pc_plus4 = pc + XLEN'(4);
   assign br_tgt   = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
   assign jmp_tgt  = {pc_plus4[XLEN-1:XLEN-4], f_tgt, 2'b00};

   always_comb begin
      if (ctrl.jump)                  pc_next = jmp_tgt;
      else if (ctrl.branch && alu_zero) pc_next = br_tgt;
      else                            pc_next = pc_plus4;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= RESET_PC;
      else        pc <= pc_next;
   end

   assign imem_addr = pc;

endmodule

// File: rtl/oc_core_chk.sv
module oc_core_chk #(
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] imem_addr,
   input logic [31:0] imem_data,
   input logic        dmem_we,
   input logic        rf_we,
   input logic [31:0] rs_val,
   input logic [31:0] rt_val
);

   logic [5:0]  c_op;
   logic [31:0] c_pc4, c_br, c_jmp;
   logic        c_known, c_ctl;

   assign c_op    = imem_data[31:26];
   assign c_pc4   = imem_addr + 32'd4;
   assign c_br    = c_pc4 + {{14{imem_data[15]}}, imem_data[15:0], 2'b00};
   assign c_jmp   = {c_pc4[31:28], imem_data[25:0], 2'b00};
   assign c_ctl   = (c_op == 6'h04) || (c_op == 6'h02);
   assign c_known = (c_op == 6'h00) || (c_op == 6'h08) || (c_op == 6'h23) ||
                    (c_op == 6'h2B) || c_ctl;

   // R1: no store while held in reset
   always_comb begin
      if (rst_n === 1'b0) begin
         a_r1_no_store_in_reset: assert (dmem_we == 1'b0);
         a_r1_reset_pc: assert (imem_addr == RESET_PC);
      end
   end

   a_r4_store_only_op: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |-> (c_op == 6'h2B));

   a_r5_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
      (c_op == 6'h04 && rs_val == rt_val) |=> imem_addr == $past(c_br));

   a_r5_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (c_op == 6'h04 && rs_val != rt_val) |=> imem_addr == $past(c_pc4));

   a_r6_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
      (c_op == 6'h02) |=> imem_addr == $past(c_jmp));

   a_r7_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (imem_data[25:21] == 5'd0) |-> (rs_val == 32'd0));

   a_r8_unknown_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !c_known |-> (!dmem_we && !rf_we));

   a_r9_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      !c_ctl |=> imem_addr == $past(c_pc4));

endmodule

bind onecycle_core oc_core_chk #(.RESET_PC(RESET_PC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .imem_addr (imem_addr),
   .imem_data (imem_data),
   .dmem_we   (dmem_we),
   .rf_we     (rf_we),
   .rs_val    (rs_val),
   .rt_val    (rt_val)
);

// File: tb/sim_onecycle_core.sv
module sim_onecycle_core;

   localparam int CLK_PERIOD = 10;
   localparam int HALT_IDX   = 37;
   localparam int MAX_CYC    = 2000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;

   logic [31:0] imem [256];
   logic [31:0] dmem [256];

   int n_checks = 0;
   int n_fail   = 0;

   logic [31:0] q_addr[$];
   logic [31:0] q_data[$];
   string       q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   onecycle_core u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_data  (imem_data),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata)
   );

   assign imem_data  = imem[imem_addr[9:2]];
   assign dmem_rdata = dmem[dmem_addr[9:2]];

   always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

   function automatic logic [31:0] r_ins(int fn, int rs, int rt, int rd);
      return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
   endfunction
   function automatic logic [31:0] i_ins(int op, int rs, int rt, int imm);
      return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
   endfunction
   function automatic logic [31:0] j_ins(int tgt);
      return {6'h02, tgt[25:0]};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Driver side of the scoreboard
   task automatic expect_store(logic [31:0] a, logic [31:0] d, string tag);
      q_addr.push_back(a);
      q_data.push_back(d);
      q_tag.push_back(tag);
   endtask

   // Monitor: every store is popped and compared
   always @(negedge clk) begin
      if (rst_n && dmem_we) begin
         if (q_addr.size() == 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8/R5/R6 unexpected store: actual %h@%h expected none",
                     dmem_wdata, dmem_addr);
         end else begin
            logic [31:0] ea, ed;
            string t;
            ea = q_addr.pop_front();
            ed = q_data.pop_front();
            t  = q_tag.pop_front();
            check({t, " addr"}, dmem_addr, ea);
            check({t, " data"}, dmem_wdata, ed);
         end
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         imem[i] = 32'h0;
         dmem[i] = 32'h0;
      end
      dmem[16] = 32'h1234_5678;
      dmem[17] = 32'hFFFF_FFF0;

      imem[0]  = i_ins(8'h08, 0, 1, 5);
      imem[1]  = i_ins(8'h08, 0, 2, -3);
      imem[2]  = r_ins(8'h20, 1, 2, 3);
      imem[3]  = r_ins(8'h22, 1, 2, 4);
      imem[4]  = i_ins(8'h2B, 0, 3, 32'h80);
      imem[5]  = i_ins(8'h2B, 0, 4, 32'h84);
      imem[6]  = i_ins(8'h23, 0, 5, 32'h40);
      imem[7]  = i_ins(8'h08, 0, 7, 32'h48);
      imem[8]  = i_ins(8'h23, 7, 6, -4);
      imem[9]  = i_ins(8'h08, 0, 0, 7);
      imem[10] = i_ins(8'h2B, 0, 0, 32'h88);
      imem[11] = i_ins(8'h2B, 0, 5, 32'h8C);
      imem[12] = i_ins(8'h2B, 7, 6, 32'h48);
      imem[13] = r_ins(8'h24, 5, 6, 8);
      imem[14] = r_ins(8'h25, 1, 4, 9);
      imem[15] = r_ins(8'h2A, 2, 1, 10);
      imem[16] = i_ins(8'h2B, 0, 8, 32'h94);
      imem[17] = i_ins(8'h2B, 0, 9, 32'h98);
      imem[18] = i_ins(8'h2B, 0, 10, 32'h9C);
      imem[19] = i_ins(8'h3F, 0, 1, 32'h88);
      imem[20] = r_ins(8'h3F, 1, 1, 1);
      imem[21] = i_ins(8'h2B, 0, 1, 32'hA0);
      imem[22] = i_ins(8'h04, 1, 2, 1);
      imem[23] = i_ins(8'h08, 0, 12, 1);
      imem[24] = i_ins(8'h04, 3, 3, 2);
      imem[25] = i_ins(8'h08, 12, 12, 100);
      imem[26] = i_ins(8'h08, 12, 12, 200);
      imem[27] = i_ins(8'h08, 12, 12, 16);
      imem[28] = i_ins(8'h2B, 0, 12, 32'hA4);
      imem[29] = j_ins(31);
      imem[30] = i_ins(8'h2B, 0, 1, 32'hA8);
      imem[31] = i_ins(8'h08, 0, 13, 3);
      imem[32] = i_ins(8'h08, 14, 14, 2);
      imem[33] = i_ins(8'h08, 13, 13, -1);
      imem[34] = i_ins(8'h04, 13, 0, 1);
      imem[35] = i_ins(8'h04, 0, 0, -4);
      imem[36] = i_ins(8'h2B, 0, 14, 32'hAC);
      imem[37] = j_ins(HALT_IDX);

      expect_store(32'h80, 32'd2,          "R2 add / R3 addi");
      expect_store(32'h84, 32'd8,          "R2 sub");
      expect_store(32'h88, 32'd0,          "R7 write to reg 0 ignored");
      expect_store(32'h8C, 32'h1234_5678,  "R4 load");
      expect_store(32'h90, 32'hFFFF_FFF0,  "R4 negative offset load/store");
      expect_store(32'h94, 32'h1234_5670,  "R2 and");
      expect_store(32'h98, 32'h0000_000D,  "R2 or");
      expect_store(32'h9C, 32'd1,          "R2 signed slt");
      expect_store(32'hA0, 32'd5,          "R8 unknown op/funct no write");
      expect_store(32'hA4, 32'd17,         "R5 beq not taken then taken");
      expect_store(32'hAC, 32'd6,          "R5 backward loop / R6 jump skip");

      // Reset state
      repeat (3) @(negedge clk);
      check("R1 fetch address in reset", imem_addr, 32'h0);
      check("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 one instruction per cycle", imem_addr, 32'd4);

      begin
         bit halted = 1'b0;
         for (int c = 0; c < MAX_CYC && !halted; c++) begin
            @(negedge clk);
            if (imem_addr == 32'(HALT_IDX * 4) && q_addr.size() == 0) halted = 1'b1;
         end
         if (!halted) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R6: actual pc %h expected %h", imem_addr,
                     32'(HALT_IDX * 4));
         end
      end
      repeat (3) @(negedge clk);
      check("R6 self-jump holds pc", imem_addr, 32'(HALT_IDX * 4));
      check("R8 all expected stores seen", 32'(q_addr.size()), 32'd0);
      check("R4 stored word in memory", dmem[43], 32'd6);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule